// File: doc/BRIEF.md
# Performance Counter Enable Controller

This block is a small performance-monitor unit with one free-running cycle counter and a parameterizable number of event counters (three by default). Each counter has its own enable bit. All enable bits live in one shared state, which software changes through two write-only-in-effect views. The first is a set view, where a 1 turns a counter on. The second is a clear view, where a 1 turns a counter off. A zero written to either view has no effect on the matching bit.

A global enable bit in a separate control register gates all counting. Clearing the global enable halts every counter, but the stored enable bits keep their values, so software can pause and resume monitoring without rewriting them. Event inputs are single-cycle-sampled levels: an event counter advances on each clock where its input is high, its enable bit is set and the global enable is set. Counters wrap on overflow.

The register port is a single-cycle write with a combinational read selected by the same address input. The address map is: 0 for the control register, 1 for the set view and 2 for the clear view.

Top module: `perf_cnt_ctrl`

## Requirements
- R1: After an asserted rst_ni, all enable bits and the global enable are 0, every counter reads 0, and reads at addresses 0, 1 and 2 return 0.
- R2: A write to the set view (address 1) sets each enable bit whose data bit is 1 and leaves the enable bits whose data bit is 0 unchanged. Data bit 31 maps to the cycle counter enable, and data bits 2, 1 and 0 map to event counters 2, 1 and 0.
- R3: A write to the clear view (address 2) clears each enable bit whose data bit is 1, using the same bit mapping as R2, and leaves the other enable bits unchanged. If a bit is set and cleared in the same cycle, the clear wins.
- R4: Data bits 30 down to 3 are ignored on writes to either view, and they read as 0. Control register bits 31 down to 1 are ignored on write and read as 0.
- R5: A read of either view returns the current enable state at the R2 bit positions. A read of the control register returns the global enable in bit 0.
- R6: While the global enable is 0, no counter changes value, and the stored enable bits keep their values.
- R7: The cycle counter adds one on every clock edge at which its enable bit and the global enable are both 1.
- R8: Event counter i adds one on every clock edge at which evt_i[i], its enable bit and the global enable are all 1. All counters wrap modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 set view, 2 clear view |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| evt_i | input | NUM_EVT | Event inputs, one per event counter |
| cyc_cnt_o | output | CNT_W | Cycle counter value |
| evt_cnt_o | output | NUM_EVT*CNT_W | Event counter values, counter i at bits [i*CNT_W +: CNT_W] |

## Verification
A vector table applies a sequence of writes to the set and clear views. The sequence includes all-zero data, all-one data, single-bit data, reserved-only data and mixed cycle/event masks. After each write, both views are read back. This separates true write-one-to-set and write-one-to-clear behaviour from plain overwriting, and it shows that reserved bits are discarded. Directed tests then drive event patterns in which some counters are enabled with their input low, and others are disabled with their input high, while the global enable is on and then off. This tells the individual enable gating apart from the global gating, and it confirms that the stored bits survive a pause. Long runs with a narrowed counter width check wrap-around, and a mid-run reset checks the cleared state.

// File: rtl/perf_pkg.sv
`timescale 1ns/1ps
package perf_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned CYC_BIT   = 31;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SET  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 2'd2;
endpackage

// File: rtl/perf_en_regs.sv
`timescale 1ns/1ps
module perf_en_regs
  import perf_pkg::*;
#(
  parameter int unsigned NUM_EVT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_EVT:0]  en_o,   // [NUM_EVT] = cycle counter
  output logic              gen_o
);
  localparam int unsigned EN_W = NUM_EVT + 1;

  logic [EN_W-1:0] en_q, en_d, wr_mask, set_mask, clr_mask;
  logic            gen_q;
  logic            unused_rsvd;

  // compress data bits onto the stored enable layout
  assign wr_mask     = {wdata_i[CYC_BIT], wdata_i[NUM_EVT-1:0]};
  assign unused_rsvd = ^wdata_i[CYC_BIT-1:NUM_EVT];

  assign set_mask = (wr_en_i && addr_i == ADDR_SET) ? wr_mask : '0;
  assign clr_mask = (wr_en_i && addr_i == ADDR_CLR) ? wr_mask : '0;
  assign en_d     = (en_q | set_mask) & ~clr_mask;  // clear dominates

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      gen_q <= 1'b0;
    end else begin
      en_q <= en_d;
      if (wr_en_i && addr_i == ADDR_CTRL) gen_q <= wdata_i[0];
    end
  end

  logic [DATA_W-1:0] view;
  always_comb begin
    view                 = '0;
    view[CYC_BIT]        = en_q[NUM_EVT];
    view[NUM_EVT-1:0]    = en_q[NUM_EVT-1:0];
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL:          rdata_o = {{(DATA_W-1){1'b0}}, gen_q};
      ADDR_SET, ADDR_CLR: rdata_o = view;
      default:            rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign gen_o = gen_q;
endmodule

// File: rtl/perf_counter.sv
`timescale 1ns/1ps
module perf_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = 1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + ONE;  // wraps
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/perf_cnt_ctrl.sv
`timescale 1ns/1ps
module perf_cnt_ctrl
  import perf_pkg::*;
#(
  parameter int unsigned NUM_EVT = 3,
  parameter int unsigned CNT_W   = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [NUM_EVT-1:0]       evt_i,
  output logic [CNT_W-1:0]         cyc_cnt_o,
  output logic [NUM_EVT*CNT_W-1:0] evt_cnt_o
);
  logic [NUM_EVT:0] en_q;
  logic             gen_q;

  perf_en_regs #(.NUM_EVT(NUM_EVT)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .en_o    (en_q),
    .gen_o   (gen_q)
  );

  perf_counter #(.CNT_W(CNT_W)) u_cyc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (gen_q & en_q[NUM_EVT]),
    .cnt_o  (cyc_cnt_o)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    perf_counter #(.CNT_W(CNT_W)) u_evt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (gen_q & en_q[i] & evt_i[i]),
      .cnt_o  (evt_cnt_o[i*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/perf_cnt_ctrl_chk.sv
`timescale 1ns/1ps
module perf_cnt_ctrl_chk
  import perf_pkg::*;
#(
  parameter int unsigned NUM_EVT = 3,
  parameter int unsigned CNT_W   = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [DATA_W-1:0]        wdata_i,
  input logic [DATA_W-1:0]        rdata_o,
  input logic [NUM_EVT-1:0]       evt_i,
  input logic [NUM_EVT:0]         en_q,
  input logic                     gen_q,
  input logic [CNT_W-1:0]         cyc_cnt_o,
  input logic [NUM_EVT*CNT_W-1:0] evt_cnt_o
);
  localparam logic [CNT_W-1:0] ONE = 1;
  logic [NUM_EVT:0] mask;
  assign mask = {wdata_i[CYC_BIT], wdata_i[NUM_EVT-1:0]};

  AST_SET_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_SET) |=> en_q == ($past(en_q) | $past(mask))); // R2

  AST_CLR_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CLR) |=> en_q == ($past(en_q) & ~$past(mask))); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[CYC_BIT-1:NUM_EVT] == '0); // R4

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == ADDR_SET || addr_i == ADDR_CLR)) |=> $stable(en_q)); // R6

  AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_q |=> ($stable(cyc_cnt_o) && $stable(evt_cnt_o))); // R6

  AST_CYC_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_q && en_q[NUM_EVT]) |=> cyc_cnt_o == $past(cyc_cnt_o) + ONE); // R7

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
    AST_EVT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gen_q && en_q[i] && evt_i[i]) |=>
        evt_cnt_o[i*CNT_W +: CNT_W] == $past(evt_cnt_o[i*CNT_W +: CNT_W]) + ONE); // R8
    AST_EVT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(gen_q && en_q[i] && evt_i[i]) |=> $stable(evt_cnt_o[i*CNT_W +: CNT_W])); // R8
  end
endmodule

bind perf_cnt_ctrl perf_cnt_ctrl_chk #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .evt_i     (evt_i),
  .en_q      (en_q),
  .gen_q     (gen_q),
  .cyc_cnt_o (cyc_cnt_o),
  .evt_cnt_o (evt_cnt_o)
);

// File: tb/sim_perf_cnt_ctrl.sv
`timescale 1ns/1ps
module sim_perf_cnt_ctrl;
  localparam int unsigned NE = 3;
  localparam int unsigned CW = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           wr_en_i = 1'b0;
  logic [1:0]     addr_i = 2'd0;
  logic [31:0]    wdata_i = '0;
  logic [31:0]    rdata_o;
  logic [NE-1:0]  evt_i = '0;
  logic [CW-1:0]  cyc_cnt_o;
  logic [NE*CW-1:0] evt_cnt_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  perf_cnt_ctrl #(.NUM_EVT(NE), .CNT_W(CW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i),
    .cyc_cnt_o(cyc_cnt_o), .evt_cnt_o(evt_cnt_o)
  );

  // {addr, wdata, expected view after write}
  localparam int NV = 9;
  localparam logic [65:0] VEC [NV] = '{
    {2'd1, 32'h0000_0001, 32'h0000_0001},
    {2'd1, 32'h0000_0000, 32'h0000_0001},
    {2'd1, 32'h8000_0004, 32'h8000_0005},
    {2'd1, 32'h7FFF_FFF8, 32'h8000_0005},
    {2'd2, 32'h0000_0000, 32'h8000_0005},
    {2'd2, 32'h0000_0001, 32'h8000_0004},
    {2'd1, 32'hFFFF_FFFF, 32'h8000_0007},
    {2'd2, 32'h8000_0002, 32'h0000_0005},
    {2'd2, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  function automatic logic [CW-1:0] ecnt(input int i);
    return evt_cnt_o[i*CW +: CW];
  endfunction

  task automatic chk_reset_state(input string tag);
    logic [31:0] r;
    rd(2'd0, r); chk({tag, " ctrl"}, r, 32'h0);
    rd(2'd1, r); chk({tag, " set view"}, r, 32'h0);
    rd(2'd2, r); chk({tag, " clr view"}, r, 32'h0);
    chk({tag, " cyc"}, {24'h0, cyc_cnt_o}, 32'h0);
    chk({tag, " evt"}, {8'h0, evt_cnt_o}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [CW-1:0] s, s0;
    repeat (2) @(negedge clk_i);
    chk_reset_state("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // vector walk with global enable off
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][65:64], VEC[k][63:32]);
      rd(2'd1, r); chk($sformatf("R2/R3/R4/R5 vec %0d set view", k), r, VEC[k][31:0]);
      rd(2'd2, r); chk($sformatf("R2/R3/R4/R5 vec %0d clr view", k), r, VEC[k][31:0]);
      @(negedge clk_i);
    end
    chk("R6 cyc held during vectors", {24'h0, cyc_cnt_o}, 32'h0);

    // enables set, global off: nothing counts
    wr(2'd1, 32'h8000_0003);
    evt_i = 3'b111;
    repeat (10) @(negedge clk_i);
    evt_i = 3'b000;
    chk("R6 cyc gated", {24'h0, cyc_cnt_o}, 32'h0);
    chk("R6 evt gated", {8'h0, evt_cnt_o}, 32'h0);
    rd(2'd1, r); chk("R6 enables kept", r, 32'h8000_0003);

    // global on
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, r); chk("R5 ctrl readback", r, 32'h1);
    s0 = cyc_cnt_o;
    evt_i = 3'b101;
    repeat (5) @(negedge clk_i);
    evt_i = 3'b000;
    repeat (5) @(negedge clk_i);
    chk("R7 cyc +10", {24'h0, cyc_cnt_o - s0}, 32'd10);
    chk("R8 evt0 +5", {24'h0, ecnt(0)}, 32'd5);
    chk("R8 evt1 low input", {24'h0, ecnt(1)}, 32'd0);
    chk("R8 evt2 disabled", {24'h0, ecnt(2)}, 32'd0);

    // clear cycle enable
    wr(2'd2, 32'h8000_0000);
    s = cyc_cnt_o;
    repeat (5) @(negedge clk_i);
    chk("R3 cyc stopped", {24'h0, cyc_cnt_o}, {24'h0, s});
    rd(2'd1, r); chk("R3 other bits kept", r, 32'h0000_0003);

    // global off while enabled, events high
    wr(2'd0, 32'h0);
    s = ecnt(0);
    evt_i = 3'b011;
    repeat (5) @(negedge clk_i);
    evt_i = 3'b000;
    chk("R6 evt0 paused", {24'h0, ecnt(0)}, {24'h0, s});
    rd(2'd2, r); chk("R6 enables kept after pause", r, 32'h0000_0003);

    // control reserved bits
    wr(2'd0, 32'hFFFF_FFFE);
    rd(2'd0, r); chk("R4 ctrl rsvd ignored", r, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, r); chk("R4 ctrl reads bit0 only", r, 32'h1);

    // wrap tests (CNT_W = 8)
    wr(2'd1, 32'h8000_0000);
    s = cyc_cnt_o;
    repeat (300) @(negedge clk_i);
    chk("R8 cyc wrap", {24'h0, cyc_cnt_o}, {24'h0, s + 8'd44});
    s = ecnt(0);
    evt_i = 3'b001;
    repeat (260) @(negedge clk_i);
    evt_i = 3'b000;
    chk("R8 evt0 wrap", {24'h0, ecnt(0)}, {24'h0, s + 8'd4});

    // reset mid-run
    rst_ni = 1'b0;
    #1;
    chk_reset_state("R1 mid-run reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule